// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records when rising edges occur on an asynchronous digital input. A free-running timebase counter advances once per prescaled tick and returns to zero after it reaches a programmable reload value. A rising edge on the synchronised input copies the current count into a capture register and marks the capture as valid. The consumer collects the capture with a read strobe, which clears the valid mark.

If a second edge arrives before the previous capture has been read, the earlier timestamp is lost. The block records this in a sticky over-capture flag. While that flag is set, a read reports an error code instead of a value. A status code shows at all times what a read would return: nothing new, a fresh value, or an error. Captures happen only while the enable input is high. The timebase runs whatever the state of the enable input.

Top module: `edge_stamp_unit`

## Requirements
- R1: While reset is active and directly after it, `stamp_valid` and `ovr_flag` are 0, `stamp_value` is 0 and `timer_now` is 0.
- R2: `timer_now` advances only on prescaler ticks. The prescaler counts clock cycles from 0. It emits a tick and returns to 0 in any cycle in which its count is greater than or equal to `psc_cfg`. This gives one advance every `psc_cfg`+1 cycles.
- R3: On a tick, `timer_now` becomes 0 if it is greater than or equal to `reload_cfg`. Otherwise it increases by 1.
- R4: `sig_async` passes through two synchroniser flops and then a rising-edge detector. A rise that is first sampled at clock edge k causes a capture at clock edge k+2. `stamp_value` then holds the `timer_now` value seen in the cycle before edge k+2, and `stamp_valid` is 1.
- R5: While `enable` is 0, edges cause no capture. `stamp_value` and `stamp_valid` stay unchanged unless a read occurs.
- R6: `rd_code` is 2'b10 (error) when `ovr_flag` is 1. Otherwise it is 2'b01 (value) when `stamp_valid` is 1, and 2'b00 (none) in all other cases. A `rd_strobe` cycle clears `stamp_valid` at the next clock edge.
- R7: A capture while `stamp_valid` is 1 and no read is strobed sets `ovr_flag` and overwrites `stamp_value`. `ovr_flag` stays set until `ovr_clr` is pulsed. If a new over-capture happens in the same cycle as `ovr_clr`, the flag stays set.
- R8: If a read and a capture fall in the same cycle, `stamp_valid` stays 1, `stamp_value` takes the new count, and `ovr_flag` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Capture enable |
| sig_async | input | 1 | Asynchronous input whose rising edges are timestamped |
| psc_cfg | input | PSC_W | Prescale value (division is value+1) |
| reload_cfg | input | CNT_W | Highest count before the timebase wraps |
| rd_strobe | input | 1 | Consumer read; clears the valid mark |
| ovr_clr | input | 1 | Clears the sticky over-capture flag |
| timer_now | output | CNT_W | Current timebase count |
| stamp_value | output | CNT_W | Latest captured count |
| stamp_valid | output | 1 | Capture not yet read |
| ovr_flag | output | 1 | Sticky over-capture flag |
| rd_code | output | 2 | Read result: 00 none, 01 value, 10 error |

## Verification
The hardest cases to reach are the ones where the read strobe or the flag clear lands in exactly the cycle in which a capture is made. That cycle lies two clock edges after the input rise is first sampled, behind the synchroniser, so ordinary port activity rarely hits it. The bench raises the input just after a falling clock edge. It counts two rising edges and then drives the strobe or the clear for the following edge. This makes the read-versus-capture and set-versus-clear priorities visible at the ports. A reference model of the timebase, built from the prescale and wrap rules, supplies the expected timestamp for every capture.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

    typedef enum logic [1:0] {
        RD_NONE  = 2'b00,
        RD_VALUE = 2'b01,
        RD_ERROR = 2'b10
    } rd_code_e;

endpackage

// File: rtl/es_input_sync.sv
module es_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The newest synchronised bit against its delayed copy.
    assign rise_pulse = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/es_timebase.sv
module es_timebase #(
    parameter int PSC_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc_cfg,
    input  logic [CNT_W-1:0] reload_cfg,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.psc >= psc_cfg);
        if (tick) begin
            st_d.psc = '0;
            if (st_q.cnt >= reload_cfg) st_d.cnt = '0;
            else                        st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.psc = st_q.psc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count >= reload_cfg) |=> count == '0);

endmodule

// File: rtl/es_capture.sv
module es_capture
    import edge_stamp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rise_pulse,
    input  logic [CNT_W-1:0] count,
    input  logic             rd_strobe,
    input  logic             ovr_clr,
    output logic [CNT_W-1:0] stamp,
    output logic             valid,
    output logic             ovr,
    output rd_code_e         code
);
    typedef struct packed {
        logic [CNT_W-1:0] stamp;
        logic             valid;
        logic             ovr;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        st_d = st_q;
        fire = enable & rise_pulse;
        if (fire) begin
            st_d.stamp = count;
            st_d.valid = 1'b1;
        end else if (rd_strobe) begin
            st_d.valid = 1'b0;
        end
        if (fire && st_q.valid && !rd_strobe) st_d.ovr = 1'b1;
        else if (ovr_clr)                     st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.ovr)        code = RD_ERROR;
        else if (st_q.valid) code = RD_VALUE;
        else                 code = RD_NONE;
    end

    assign stamp = st_q.stamp;
    assign valid = st_q.valid;
    assign ovr   = st_q.ovr;

    a_r4_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rise_pulse) |=> valid && stamp == $past(count));

    a_r5_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !rd_strobe) |=> $stable(valid) && $stable(stamp));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !(enable && rise_pulse)) |=> !valid);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    a_r8_read_vs_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rise_pulse && rd_strobe && !ovr_clr) |=> valid && ovr == $past(ovr));

endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
    import edge_stamp_pkg::*;
#(
    parameter int PSC_W       = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sig_async,
    input  logic [PSC_W-1:0] psc_cfg,
    input  logic [CNT_W-1:0] reload_cfg,
    input  logic             rd_strobe,
    input  logic             ovr_clr,
    output logic [CNT_W-1:0] timer_now,
    output logic [CNT_W-1:0] stamp_value,
    output logic             stamp_valid,
    output logic             ovr_flag,
    output logic [1:0]       rd_code
);
    logic     rise_pulse;
    rd_code_e code_e;

    es_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (sig_async),
        .rise_pulse (rise_pulse)
    );

    es_timebase #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .psc_cfg    (psc_cfg),
        .reload_cfg (reload_cfg),
        .count      (timer_now)
    );

    es_capture #(.CNT_W(CNT_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .rise_pulse (rise_pulse),
        .count      (timer_now),
        .rd_strobe  (rd_strobe),
        .ovr_clr    (ovr_clr),
        .stamp      (stamp_value),
        .valid      (stamp_valid),
        .ovr        (ovr_flag),
        .code       (code_e)
    );

    assign rd_code = code_e;

    a_r6_code_error: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |-> rd_code == 2'b10);

endmodule

// File: tb/edge_stamp_unit_bench.sv
module edge_stamp_unit_bench;
    localparam int PSC_W = 8;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             sig_async = 1'b0;
    logic [PSC_W-1:0] psc_cfg = '0;
    logic [CNT_W-1:0] reload_cfg = 16'd9;
    logic             rd_strobe = 1'b0;
    logic             ovr_clr = 1'b0;
    logic [CNT_W-1:0] timer_now, stamp_value;
    logic             stamp_valid, ovr_flag;
    logic [1:0]       rd_code;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    edge_stamp_unit #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_edge_stamp_unit (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sig_async(sig_async),
        .psc_cfg(psc_cfg), .reload_cfg(reload_cfg), .rd_strobe(rd_strobe),
        .ovr_clr(ovr_clr), .timer_now(timer_now), .stamp_value(stamp_value),
        .stamp_valid(stamp_valid), .ovr_flag(ovr_flag), .rd_code(rd_code)
    );

    // Timebase reference built from R2 and R3.
    logic [PSC_W-1:0] m_psc = '0;
    logic [CNT_W-1:0] m_cnt = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_psc <= '0;
            m_cnt <= '0;
        end else if (m_psc >= psc_cfg) begin
            m_psc <= '0;
            m_cnt <= (m_cnt >= reload_cfg) ? '0 : m_cnt + 1'b1;
        end else begin
            m_psc <= m_psc + 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Raise the input; the capture edge gets the optional read/clear.
    task automatic pulse(input bit rd_at_cap, input bit clr_at_cap, output logic [CNT_W-1:0] exp);
        repeat (3) @(negedge clk);
        sig_async = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        sig_async = 1'b0;
        exp = m_cnt;
        rd_strobe = rd_at_cap;
        ovr_clr = clr_at_cap;
        @(negedge clk);
        rd_strobe = 1'b0;
        ovr_clr = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] reload;
        logic [7:0]       idle;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'd0, 16'd9,     8'd3},
        '{8'd2, 16'd5,     8'd7},
        '{8'd0, 16'd3,     8'd11},
        '{8'd4, 16'd20,    8'd2},
        '{8'd1, 16'd0,     8'd5},
        '{8'd3, 16'd65535, 8'd13},
        '{8'd7, 16'd2,     8'd40}
    };

    initial begin
        logic [CNT_W-1:0] exp, prev;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(stamp_valid == 0, "R1 valid", stamp_valid, 0);
        check(ovr_flag == 0, "R1 ovr", ovr_flag, 0);
        check(stamp_value == 0, "R1 stamp", stamp_value, 0);
        check(timer_now == 0, "R1 timer", timer_now, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_code == 2'b00, "R1 code", rd_code, 0);
        enable = 1'b1;

        foreach (VECS[i]) begin
            psc_cfg = VECS[i].psc;
            reload_cfg = VECS[i].reload;
            for (int c = 0; c < int'(VECS[i].idle); c++) begin
                @(negedge clk);
                check(timer_now == m_cnt, "R2 R3 timebase", timer_now, m_cnt);
            end
            pulse(1'b0, 1'b0, exp);
            check(stamp_value == exp, "R4 stamp", stamp_value, exp);
            check(stamp_valid == 1, "R4 valid", stamp_valid, 1);
            check(rd_code == 2'b01, "R6 code value", rd_code, 1);
            do_read();
            check(stamp_valid == 0, "R6 read clears", stamp_valid, 0);
            check(rd_code == 2'b00, "R6 code none", rd_code, 0);
        end

        // R5: disabled edge leaves capture alone
        prev = stamp_value;
        enable = 1'b0;
        pulse(1'b0, 1'b0, exp);
        check(stamp_valid == 0, "R5 no valid", stamp_valid, 0);
        check(stamp_value == prev, "R5 stamp held", stamp_value, prev);
        enable = 1'b1;

        // R7: overwrite of an unread capture
        pulse(1'b0, 1'b0, exp);
        pulse(1'b0, 1'b0, exp);
        check(ovr_flag == 1, "R7 ovr set", ovr_flag, 1);
        check(stamp_value == exp, "R7 overwritten", stamp_value, exp);
        check(rd_code == 2'b10, "R6 code error", rd_code, 2);
        do_read();
        check(ovr_flag == 1, "R7 sticky after read", ovr_flag, 1);
        check(stamp_valid == 0, "R6 valid cleared", stamp_valid, 0);
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check(ovr_flag == 0, "R7 cleared", ovr_flag, 0);

        // R7: new over-capture beats a simultaneous clear
        pulse(1'b0, 1'b0, exp);
        pulse(1'b0, 1'b1, exp);
        check(ovr_flag == 1, "R7 set beats clear", ovr_flag, 1);
        do_read();
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;

        // R8: read coinciding with a capture
        pulse(1'b0, 1'b0, exp);
        pulse(1'b1, 1'b0, exp);
        check(stamp_valid == 1, "R8 valid kept", stamp_valid, 1);
        check(ovr_flag == 0, "R8 no ovr", ovr_flag, 0);
        check(stamp_value == exp, "R8 new stamp", stamp_value, exp);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule